// File: doc/BRIEF.md
# Digital Automatic Level Control

This block keeps a stereo stream of signed PCM samples below a programmable level by steering one 8-bit gain code per channel. Each code step is 0.375 dB. Code 145 (91h) is unity, 241 (F1h) is about +36 dB, 1 is about −54 dB and 0 mutes. Every valid sample is scaled by its channel's current code and saturated, then registered out together with the updated code.

When the level control is enabled, the two channels work independently. If a scaled sample exceeds the limit threshold, the gain is lowered at the next update point. If no sample exceeds it, the gain climbs toward a reference code. Update points are sign changes between consecutive samples, or a sample-count timeout. Recovery can be sped up by a multiplier. When the control is disabled, a manually programmed code is used directly. After a disable, a new enable is held off for one timeout period of samples.

Top module: `auto_level_ctrl`

## Requirements
- R1: For a code c other than 0, the output equals floor(s · m · 2^(e−25)) with t = c + 15, e = t div 16, and m = round(32768 · 2^((t mod 16)/16)). Code 91h therefore gives exactly s, A1h gives 2s, and code 0 gives 0.
- R2: A scaled value above 2^(W−1)−1 or below −2^(W−1) is clamped to that limit.
- R3: While the control is inactive, both gain codes take the manual code on the next clock, and samples are scaled by it.
- R4: Each valid sample produces exactly one out_valid pulse one clock later. The gain codes change on that same edge, and a cycle without a sample produces no output pulse.
- R5: Suppose a scaled sample's magnitude exceeds lim_thresh at an update point, or on any sample since the last update point. Then the gain drops by atk_step+1 codes at that update point, and never goes below code 1 unless it was already 0.
- R6: An update point is a valid sample whose sign bit differs from the previous valid sample of that channel, or the (128 << tmo_sel)-th sample since the last update point. At other samples the gain holds.
- R7: At an update point with no excess level, a gain below ref_code rises by rec_step+1 codes, capped at ref_code. A gain at or above ref_code is left unchanged.
- R8: With fast_en set, the recovery step is multiplied by 4, 8 or 16 for fast_sel 0, 1 or 2. fast_sel 3 leaves the step unmultiplied.
- R9: After en falls while the control is active, en is ignored until 128 << tmo_sel further valid samples have arrived. During that time the manual code is passed through.
- R10: During reset, out_valid, both outputs and both gain codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable automatic control |
| samp_valid | input | 1 | Sample strobe for both channels |
| samp_l | input | W | Left sample, signed |
| samp_r | input | W | Right sample, signed |
| man_code | input | 8 | Gain code used while inactive |
| ref_code | input | 8 | Recovery ceiling code |
| lim_thresh | input | W−1 | Limit magnitude |
| atk_step | input | 2 | Attack step minus one |
| rec_step | input | 2 | Recovery step minus one |
| tmo_sel | input | 2 | Timeout of 128 << tmo_sel samples |
| fast_en | input | 1 | Fast recovery enable |
| fast_sel | input | 2 | Fast recovery multiplier select |
| out_valid | output | 1 | Scaled samples valid |
| out_l | output | W | Left scaled sample |
| out_r | output | W | Right scaled sample |
| gain_l | output | 8 | Left gain code |
| gain_r | output | 8 | Right gain code |

## Verification
The properties assume that reset is held for at least one clock at start-up. They also assume that the control fields change only between samples, so that a gain step seen at one edge comes from the attack and recovery settings present there. The stimulus changes every field at a falling clock edge and follows each change with idle cycles. Sample strobes are single-cycle pulses, and enable transitions never coincide with a sample.

// File: rtl/alc_pkg.sv
package alc_pkg;
  typedef logic [7:0] gcode_t;

  localparam int CODE_BIAS  = 15;
  localparam int SHIFT_BASE = 25;
  localparam int MANT_W     = 16;

  // Q15 mantissa 2^(k/16), k = 0..15
  function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] k);
    logic [MANT_W-1:0] m;
    case (k)
      4'd0:  m = 16'd32768;
      4'd1:  m = 16'd34219;
      4'd2:  m = 16'd35734;
      4'd3:  m = 16'd37316;
      4'd4:  m = 16'd38968;
      4'd5:  m = 16'd40693;
      4'd6:  m = 16'd42495;
      4'd7:  m = 16'd44376;
      4'd8:  m = 16'd46341;
      4'd9:  m = 16'd48393;
      4'd10: m = 16'd50535;
      4'd11: m = 16'd52773;
      4'd12: m = 16'd55109;
      4'd13: m = 16'd57549;
      4'd14: m = 16'd60097;
      default: m = 16'd62757;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alc_scale.sv
module alc_scale
  import alc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic signed [W-1:0] din,
  input  gcode_t              code,
  output logic signed [W-1:0] dout,
  output logic        [W-1:0] mag
);
  localparam int PW = W + MANT_W + 1;
  localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic        [8:0]    t;
  logic        [4:0]    ex;
  logic signed [PW-1:0] a_ext, m_ext, prod, shd;

  always_comb begin
    t     = {1'b0, code} + 9'(CODE_BIAS);
    ex    = t[8:4];
    a_ext = PW'(din);
    m_ext = PW'($signed({1'b0, mant_of(t[3:0])}));
    prod  = a_ext * m_ext;
    shd   = prod >>> (5'(SHIFT_BASE) - ex);
    if (code == '0)            dout = '0;
    else if (shd > PW'(SMAX))  dout = SMAX;
    else if (shd < PW'(SMIN))  dout = SMIN;
    else                       dout = shd[W-1:0];
    mag = dout[W-1] ? W'(-dout) : W'(dout);
  end
endmodule

// File: rtl/alc_chan.sv
module alc_chan
  import alc_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                act,
  input  logic                valid,
  input  logic signed [W-1:0] din,
  input  gcode_t              man_code,
  input  gcode_t              ref_code,
  input  logic [W-2:0]        thr,
  input  logic [1:0]          atk_sel,
  input  logic [1:0]          rec_sel,
  input  logic                fast_en,
  input  logic [1:0]          fast_sel,
  input  logic [CNT_W-1:0]    tmo_last,
  output gcode_t              gain,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] scaled;
  logic        [W-1:0] mag;
  logic                over, zc, upd, pend, psign;
  logic [CNT_W-1:0]    cnt;
  logic [2:0]          atk;
  logic [6:0]          rstep;
  logic [8:0]          up_sum;
  gcode_t              next_gain;

  alc_scale #(.W(W)) u_scale (
    .din  (din),
    .code (gain),
    .dout (scaled),
    .mag  (mag)
  );

  always_comb begin
    over   = mag > {1'b0, thr};
    zc     = din[W-1] != psign;
    upd    = zc || (cnt == tmo_last);
    atk    = {1'b0, atk_sel} + 3'd1;
    rstep  = {5'd0, rec_sel} + 7'd1;
    if (fast_en && fast_sel != 2'd3)
      rstep = rstep << (3'd2 + {1'b0, fast_sel});
    up_sum    = {1'b0, gain} + {2'b0, rstep};
    next_gain = gain;
    if (pend || over) begin
      if (gain > {5'd0, atk})  next_gain = gain - {5'd0, atk};
      else if (gain != '0)     next_gain = 8'd1;
    end else if (gain < ref_code) begin
      next_gain = (up_sum > {1'b0, ref_code}) ? ref_code : up_sum[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gain  <= '0;
      dout  <= '0;
      cnt   <= '0;
      pend  <= 1'b0;
      psign <= 1'b0;
    end else begin
      if (valid) begin
        dout  <= scaled;
        psign <= din[W-1];
      end
      if (!act) begin
        gain <= man_code;
        cnt  <= '0;
        pend <= 1'b0;
      end else if (valid) begin
        if (upd) begin
          gain <= next_gain;
          cnt  <= '0;
          pend <= 1'b0;
        end else begin
          cnt  <= cnt + 1'b1;
          pend <= pend | over;
        end
      end
    end
  end
endmodule

// File: rtl/alc_lockout.sv
module alc_lockout #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             valid,
  input  logic [CNT_W-1:0] tmo_last,
  output logic             act
);
  logic [CNT_W:0] left;
  logic           act_q;

  assign act = en && (left == '0) && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= act;
      if (act_q && !en)
        left <= {1'b0, tmo_last} + 1'b1;
      else if (valid && left != '0)
        left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/auto_level_ctrl.sv
module auto_level_ctrl #(
  parameter int W        = 16,
  parameter int TMO_BASE = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                samp_valid,
  input  logic signed [W-1:0] samp_l,
  input  logic signed [W-1:0] samp_r,
  input  logic [7:0]          man_code,
  input  logic [7:0]          ref_code,
  input  logic [W-2:0]        lim_thresh,
  input  logic [1:0]          atk_step,
  input  logic [1:0]          rec_step,
  input  logic [1:0]          tmo_sel,
  input  logic                fast_en,
  input  logic [1:0]          fast_sel,
  output logic                out_valid,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_r,
  output logic [7:0]          gain_l,
  output logic [7:0]          gain_r
);
  localparam int CNT_W = $clog2(TMO_BASE * 8);
  localparam int NCH   = 2;

  logic [CNT_W-1:0]    tmo_last;
  logic                act;
  logic signed [W-1:0] din_a  [NCH];
  logic signed [W-1:0] dout_a [NCH];
  logic [7:0]          gain_a [NCH];

  assign tmo_last = CNT_W'((TMO_BASE << tmo_sel) - 1);
  assign din_a[0] = samp_l;
  assign din_a[1] = samp_r;

  alc_lockout #(.CNT_W(CNT_W)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .valid    (samp_valid),
    .tmo_last (tmo_last),
    .act      (act)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    alc_chan #(.W(W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .act      (act),
      .valid    (samp_valid),
      .din      (din_a[c]),
      .man_code (man_code),
      .ref_code (ref_code),
      .thr      (lim_thresh),
      .atk_sel  (atk_step),
      .rec_sel  (rec_step),
      .fast_en  (fast_en),
      .fast_sel (fast_sel),
      .tmo_last (tmo_last),
      .gain     (gain_a[c]),
      .dout     (dout_a[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= samp_valid;
  end

  assign out_l  = dout_a[0];
  assign out_r  = dout_a[1];
  assign gain_l = gain_a[0];
  assign gain_r = gain_a[1];
endmodule

// File: rtl/alc_checker.sv
module alc_checker (
  input logic       clk,
  input logic       rst,
  input logic       act,
  input logic       samp_valid,
  input logic       out_valid,
  input logic [7:0] man_code,
  input logic [7:0] ref_code,
  input logic [7:0] gain_l,
  input logic [7:0] gain_r
);
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
    samp_valid |=> out_valid);

  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !samp_valid |=> !out_valid);

  a_r3_manual_load: assert property (@(posedge clk) disable iff (rst)
    !act |=> (gain_l == $past(man_code)) && (gain_r == $past(man_code)));

  a_r6_hold_without_sample: assert property (@(posedge clk) disable iff (rst)
    act && !samp_valid |=> (gain_l == $past(gain_l)) && (gain_r == $past(gain_r)));

  a_r7_no_recover_above_ref: assert property (@(posedge clk) disable iff (rst)
    act |=> (gain_l <= $past(gain_l)) || (gain_l <= $past(ref_code)));

  a_r5_attack_bound: assert property (@(posedge clk) disable iff (rst)
    act |=> ({1'b0, gain_l} + 9'd4 >= {1'b0, $past(gain_l)}));

  a_r8_raise_bound: assert property (@(posedge clk) disable iff (rst)
    act |=> ({1'b0, gain_r} <= {1'b0, $past(gain_r)} + 9'd64));

  a_r9_lock_holds: assert property (@(posedge clk) disable iff (rst)
    $fell(act) |=> !act);
endmodule

bind auto_level_ctrl alc_checker u_alc_chk (
  .clk        (clk),
  .rst        (rst),
  .act        (act),
  .samp_valid (samp_valid),
  .out_valid  (out_valid),
  .man_code   (man_code),
  .ref_code   (ref_code),
  .gain_l     (gain_l),
  .gain_r     (gain_r)
);

// File: tb/auto_level_ctrl_tb_top.sv
module auto_level_ctrl_tb_top;
  localparam int W  = 16;
  localparam int TB = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, samp_valid = 1'b0, fast_en = 1'b0;
  logic signed [W-1:0] samp_l = '0, samp_r = '0;
  logic [7:0] man_code = 8'h91, ref_code = 8'h91;
  logic [W-2:0] lim_thresh = '1;
  logic [1:0] atk_step = 2'd0, rec_step = 2'd0, tmo_sel = 2'd0, fast_sel = 2'd0;
  logic out_valid;
  logic signed [W-1:0] out_l, out_r;
  logic [7:0] gain_l, gain_r;

  always #4 clk = ~clk;

  auto_level_ctrl #(.W(W), .TMO_BASE(TB)) dut_i (
    .clk(clk), .rst(rst), .en(en), .samp_valid(samp_valid),
    .samp_l(samp_l), .samp_r(samp_r), .man_code(man_code), .ref_code(ref_code),
    .lim_thresh(lim_thresh), .atk_step(atk_step), .rec_step(rec_step),
    .tmo_sel(tmo_sel), .fast_en(fast_en), .fast_sel(fast_sel),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
    .gain_l(gain_l), .gain_r(gain_r)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int    ql[$], qr[$], qgl[$], qgr[$];
  string qt[$];

  // reference model state
  int mg[2] = '{145, 145};
  int mcnt[2] = '{0, 0};
  bit mpend[2] = '{0, 0};
  bit mps[2] = '{0, 0};
  int mlock = 0;

  function automatic int scale_m(int s, int code);
    longint p;
    int t, mant;
    if (code == 0) return 0;
    t = code + 15;
    mant = $rtoi($pow(2.0, real'(t % 16) / 16.0) * 32768.0 + 0.5);
    p = longint'(s) * longint'(mant);
    p = p >>> (25 - t / 16);
    if (p > 32767) return 32767;
    if (p < -32768) return -32768;
    return int'(p);
  endfunction

  task automatic model_ch(input int c, input int s, input bit a, output int y);
    int mag, stepu, atkv, tlen;
    bit over, zc, upd;
    y = scale_m(s, mg[c]);
    mag = (y < 0) ? -y : y;
    if (a) begin
      tlen = TB << tmo_sel;
      over = mag > int'(lim_thresh);
      zc = (s < 0) != mps[c];
      upd = zc || (mcnt[c] == tlen - 1);
      if (upd) begin
        if (mpend[c] || over) begin
          atkv = int'(atk_step) + 1;
          if (mg[c] > atkv) mg[c] = mg[c] - atkv;
          else if (mg[c] != 0) mg[c] = 1;
        end else if (mg[c] < int'(ref_code)) begin
          stepu = int'(rec_step) + 1;
          if (fast_en && fast_sel != 2'd3) stepu = stepu * (4 << fast_sel);
          mg[c] = (mg[c] + stepu > int'(ref_code)) ? int'(ref_code) : mg[c] + stepu;
        end
        mcnt[c] = 0;
        mpend[c] = 0;
      end else begin
        mcnt[c] = mcnt[c] + 1;
        mpend[c] = mpend[c] | over;
      end
    end else begin
      mg[c] = int'(man_code);
      mcnt[c] = 0;
      mpend[c] = 0;
    end
    mps[c] = (s < 0);
  endtask

  function automatic bit model_active();
    return en && (mlock == 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int actual, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes expected results, then drives the sample for one cycle
  task automatic send(input int l, input int r, input string tag);
    bit a;
    int yl, yr;
    a = model_active();
    if (mlock > 0) mlock--;
    model_ch(0, l, a, yl);
    model_ch(1, r, a, yr);
    ql.push_back(yl); qr.push_back(yr);
    qgl.push_back(mg[0]); qgr.push_back(mg[1]); qt.push_back(tag);
    samp_l = W'(l);
    samp_r = W'(r);
    samp_valid = 1'b1;
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  task automatic set_en(input bit v);
    if (!v && model_active()) begin
      mlock = TB << tmo_sel;
      for (int c = 0; c < 2; c++) begin
        mg[c] = int'(man_code); mcnt[c] = 0; mpend[c] = 0;
      end
    end
    en = v;
    idle(2);
  endtask

  task automatic set_man(input logic [7:0] v);
    man_code = v;
    if (!model_active()) begin
      mg[0] = int'(v); mg[1] = int'(v);
    end
    idle(2);
  endtask

  task automatic drain(input string tag);
    while (mlock > 0) send(0, 0, tag);
  endtask

  task automatic alt(input int n, input int amp, input string tag);
    for (int i = 0; i < n; i++)
      send((i % 2 == 0) ? amp : -amp, (i % 2 == 0) ? -amp : amp, tag);
  endtask

  // monitor: pops and compares
  initial begin : mon
    int el, er, egl, egr;
    string et;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        n_cmp++;
        if (qt.size() == 0) begin
          n_bad++;
          $display("FAIL R4 out_valid with no sample pending: actual=1 expected=0");
        end else begin
          el = ql.pop_front(); er = qr.pop_front();
          egl = qgl.pop_front(); egr = qgr.pop_front(); et = qt.pop_front();
          if (int'(out_l) != el || int'(out_r) != er ||
              int'(gain_l) != egl || int'(gain_r) != egr) begin
            n_bad++;
            $display("FAIL %s out_l=%0d exp %0d out_r=%0d exp %0d gain_l=%0h exp %0h gain_r=%0h exp %0h",
                     et, out_l, el, out_r, er, gain_l, egl, gain_r, egr);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    idle(3);
    // R10 reset state
    chk(out_valid == 1'b0, "R10", out_valid, 0);
    chk(gain_l == 8'h00, "R10", gain_l, 0);
    chk(gain_r == 8'h00, "R10", gain_r, 0);
    chk(out_l == '0, "R10", out_l, 0);
    rst = 1'b0;
    idle(2);
    // R3 manual code passes through while inactive
    chk(gain_l == 8'h91, "R3", gain_l, 145);
    send(1000, -1000, "R3");
    send(-12345, 321, "R1");
    idle(1);
    chk(out_valid == 1'b0, "R4", out_valid, 0);
    set_man(8'hA1); send(1000, -777, "R1");
    set_man(8'h9A); send(3000, -3000, "R1");
    set_man(8'h85); send(20000, -20001, "R1");
    set_man(8'h00); send(500, -500, "R1");
    set_man(8'h3F); send(30000, -29999, "R1");
    // R2 saturation
    set_man(8'hF1); send(1000, -1000, "R2"); send(511, -512, "R2");
    send(-600, 700, "R2");
    // R7 recovery toward reference
    set_man(8'h91);
    ref_code = 8'hC1; idle(1);
    set_en(1);
    alt(60, 200, "R7");
    chk(gain_l == 8'hC1, "R7", gain_l, 193);
    // R5 limiter
    lim_thresh = 15'd4000; atk_step = 2'd1; idle(1);
    alt(40, 1000, "R5");
    lim_thresh = 15'd0; atk_step = 2'd3; idle(1);
    alt(200, 1, "R5");
    // R6 timeout with DC input, limiter pending across samples
    lim_thresh = 15'h7FFF; idle(1);
    for (int i = 0; i < 300; i++) send(100, 150, "R6");
    tmo_sel = 2'd1; idle(1);
    for (int i = 0; i < 600; i++) send(50, 60, "R6");
    lim_thresh = 15'd20; idle(1);
    for (int i = 0; i < 300; i++) send(300, 40, "R5");
    tmo_sel = 2'd0; lim_thresh = 15'h7FFF; idle(1);
    // R7 gain above reference left alone
    set_en(0);
    set_man(8'hD0);
    drain("R9");
    set_en(1);
    alt(20, 50, "R7");
    chk(gain_r == 8'hD0, "R7", gain_r, 208);
    // R8 fast recovery
    set_en(0); set_man(8'h40); drain("R9");
    ref_code = 8'hF1; rec_step = 2'd1; fast_en = 1'b1; fast_sel = 2'd1; idle(1);
    set_en(1);
    alt(12, 5, "R8");
    set_en(0); set_man(8'h40); drain("R9");
    fast_sel = 2'd2; idle(1); set_en(1); alt(8, 5, "R8");
    set_en(0); set_man(8'h40); drain("R9");
    fast_sel = 2'd3; idle(1); set_en(1); alt(10, 5, "R8");
    set_en(0); set_man(8'h40); drain("R9");
    fast_sel = 2'd0; idle(1); set_en(1); alt(10, 5, "R8");
    // R9 re-enable lockout
    fast_en = 1'b0; rec_step = 2'd0; idle(1);
    set_en(0);
    set_man(8'h70);
    set_en(1);
    alt(50, 100, "R9");
    chk(gain_l == 8'h70, "R9", gain_l, 112);
    set_man(8'h60);
    alt(40, 100, "R9");
    chk(gain_r == 8'h60, "R9", gain_r, 96);
    drain("R9");
    alt(30, 100, "R9");
    chk(gain_l > 8'h60, "R9", gain_l, 97);
    idle(4);
    chk(qt.size() == 0, "R4", qt.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule